// File: doc/BRIEF.md
# Crossing Signal Controller with Fault Flash

This block sequences the lamps of a single road crossing. It drives three vehicle lamps (red, yellow, green) and two pedestrian lamps (red, green); an output bit at 1 means the lamp is lit and 0 means it is dark. A one-clock-wide `tick` strobe marks each time unit. Every phase dwell is counted in ticks, and clocks without a tick never move the sequence.

The controller has two modes. In normal mode the vehicle lamps step through four phases: `PH_STOP` (red, 3 ticks), `PH_WARN1` (yellow, 1 tick), `PH_GO` (green, 2 ticks) and `PH_WARN2` (yellow, 1 tick), then return to `PH_STOP`. The full cycle is 7 ticks. The pedestrian lamps follow the vehicle phase: pedestrian green is lit during `PH_STOP` and pedestrian red is lit in every other phase. While the `fault` input is high the controller sits in `PH_FLASH`. In that state every lamp is dark except vehicle yellow, which toggles on each tick. The transitions are:
- STOP→WARN1, WARN1→GO, GO→WARN2 and WARN2→STOP, each on the tick that ends the dwell.
- Any normal phase→FLASH while `fault` is high.
- FLASH→STOP when `fault` is low.

Reset returns the controller to `PH_STOP`.

Top module: `crossing_signal_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the controller in `PH_STOP` with a fresh 3-tick dwell, showing vehicle red and pedestrian green. Reset wins over `fault` and `tick` in the same cycle.
- R2: In normal mode the vehicle lamps advance red→yellow→green→yellow→red. A clock edge without `tick` leaves the phase unchanged.
- R3: The phases last 3, 1, 2 and 1 ticks (red, first yellow, green, second yellow), so vehicle red returns every 7 ticks.
- R4: In normal mode pedestrian green is lit exactly while vehicle red is lit, and pedestrian red is lit in all other normal phases.
- R5: In normal mode exactly one vehicle lamp and exactly one pedestrian lamp are lit.
- R6: At the first clock edge with `fault` high, the controller enters the error mode with all five lamps dark. After that, vehicle yellow toggles on every tick, starting lit on the first tick, and the other four lamps stay dark.
- R7: When `fault` rises in the same cycle as the tick that would end a normal phase, the error mode is entered and the phase does not advance.
- R8: At the first clock edge with `fault` low while in the error mode, the controller restarts at vehicle red with a fresh 3-tick dwell. A tick in that same cycle is not counted.
- R9: Lamp output order and encoding: each of `veh_red`, `veh_yel`, `veh_grn`, `ped_red`, `ped_grn` is 1 when lit and 0 when dark. All outputs are decoded from registered state, so they change one clock after the deciding edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock time-unit strobe |
| fault | input | 1 | High selects the error (flash) mode |
| veh_red | output | 1 | Vehicle red lamp, 1 = lit |
| veh_yel | output | 1 | Vehicle yellow lamp, 1 = lit |
| veh_grn | output | 1 | Vehicle green lamp, 1 = lit |
| ped_red | output | 1 | Pedestrian red lamp, 1 = lit |
| ped_grn | output | 1 | Pedestrian green lamp, 1 = lit |

## Verification
Two functions can fall on the same clock edge: the dwell counter ending a phase on a tick, and a mode change driven by `fault`. The bench raises `fault` together with the tick that closes the one-tick first-yellow phase. It expects every lamp dark on the next cycle rather than vehicle green. It also drops `fault` together with a tick and then counts three more ticks of vehicle red, which shows that the tick in the clearing cycle was not counted toward the fresh dwell. A reset applied with `fault` held high confirms that reset takes priority over both.

// File: rtl/sig_pkg.sv
package sig_pkg;

    typedef enum logic [2:0] {
        PH_STOP  = 3'd0,
        PH_WARN1 = 3'd1,
        PH_GO    = 3'd2,
        PH_WARN2 = 3'd3,
        PH_FLASH = 3'd4
    } phase_e;

    localparam int unsigned LAMP_W = 5;

endpackage

// File: rtl/phase_fsm.sv
module phase_fsm
    import sig_pkg::*;
#(
    parameter int unsigned DW_STOP  = 3,
    parameter int unsigned DW_WARN1 = 1,
    parameter int unsigned DW_GO    = 2,
    parameter int unsigned DW_WARN2 = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   fault,
    output phase_e phase,
    output logic   err_entry
);

    localparam int unsigned MAXD12 = (DW_STOP > DW_WARN1) ? DW_STOP : DW_WARN1;
    localparam int unsigned MAXD34 = (DW_GO > DW_WARN2) ? DW_GO : DW_WARN2;
    localparam int unsigned MAXD   = (MAXD12 > MAXD34) ? MAXD12 : MAXD34;
    localparam int unsigned CW     = (MAXD > 1) ? $clog2(MAXD) : 1;

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] last_cnt;

    // Final count value of the current phase.
    always_comb begin
        unique case (state_q)
            PH_STOP:  last_cnt = CW'(DW_STOP - 1);
            PH_WARN1: last_cnt = CW'(DW_WARN1 - 1);
            PH_GO:    last_cnt = CW'(DW_GO - 1);
            PH_WARN2: last_cnt = CW'(DW_WARN2 - 1);
            default:  last_cnt = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (state_q == PH_FLASH) begin
            if (!fault) begin
                state_d = PH_STOP;
                cnt_d   = '0;
            end
        end else if (fault) begin
            state_d = PH_FLASH;
            cnt_d   = '0;
        end else if (tick) begin
            if (cnt_q == last_cnt) begin
                cnt_d = '0;
                unique case (state_q)
                    PH_STOP:  state_d = PH_WARN1;
                    PH_WARN1: state_d = PH_GO;
                    PH_GO:    state_d = PH_WARN2;
                    PH_WARN2: state_d = PH_STOP;
                    default:  state_d = PH_STOP;
                endcase
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign phase     = state_q;
    assign err_entry = fault && (state_q != PH_FLASH);

    // R6
    fault_enter_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> (state_q == PH_FLASH));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_FLASH && !fault) |=> (state_q == PH_STOP && cnt_q == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !fault && state_q != PH_FLASH) |=> $stable(state_q));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_WARN2 && tick && !fault) |=> (state_q == PH_STOP));

endmodule

// File: rtl/flash_gen.sv
module flash_gen (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic err_entry,
    input  logic in_err,
    output logic flash
);

    logic flash_q;

    always_ff @(posedge clk) begin
        if (rst || err_entry) begin
            flash_q <= 1'b0;
        end else if (in_err && tick) begin
            flash_q <= ~flash_q;
        end
    end

    assign flash = flash_q;

    // R6
    flash_start_dark_chk: assert property (@(posedge clk) disable iff (rst)
        err_entry |=> !flash_q);

endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
    import sig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              flash,
    output logic [LAMP_W-1:0] lamps
);

    // lamps = {veh_red, veh_yel, veh_grn, ped_red, ped_grn}
    always_comb begin
        unique case (phase)
            PH_STOP:  lamps = 5'b10001;
            PH_WARN1: lamps = 5'b01010;
            PH_GO:    lamps = 5'b00110;
            PH_WARN2: lamps = 5'b01010;
            PH_FLASH: lamps = {1'b0, flash, 3'b000};
            default:  lamps = 5'b10001;
        endcase
    end

    // R5
    one_lamp_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_FLASH) |-> ($countones(lamps[4:2]) == 1 && $countones(lamps[1:0]) == 1));

    // R4
    ped_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_FLASH) |-> (lamps[0] == lamps[4]));

    // R6
    dark_err_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FLASH) |-> (lamps[4] == 1'b0 && lamps[2:0] == 3'b000));

endmodule

// File: rtl/crossing_signal_ctrl.sv
module crossing_signal_ctrl
    import sig_pkg::*;
#(
    parameter int unsigned DW_STOP  = 3,
    parameter int unsigned DW_WARN1 = 1,
    parameter int unsigned DW_GO    = 2,
    parameter int unsigned DW_WARN2 = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fault,
    output logic veh_red,
    output logic veh_yel,
    output logic veh_grn,
    output logic ped_red,
    output logic ped_grn
);

    phase_e            phase;
    logic              err_entry;
    logic              flash;
    logic [LAMP_W-1:0] lamps;

    phase_fsm #(
        .DW_STOP  (DW_STOP),
        .DW_WARN1 (DW_WARN1),
        .DW_GO    (DW_GO),
        .DW_WARN2 (DW_WARN2)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .fault     (fault),
        .phase     (phase),
        .err_entry (err_entry)
    );

    flash_gen u_flash (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .err_entry (err_entry),
        .in_err    (phase == PH_FLASH && fault),
        .flash     (flash)
    );

    lamp_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .flash (flash),
        .lamps (lamps)
    );

    assign {veh_red, veh_yel, veh_grn, ped_red, ped_grn} = lamps;

endmodule

// File: tb/sim_crossing_signal_ctrl.sv
`timescale 1ns/1ps
module sim_crossing_signal_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic fault = 1'b0;
    logic veh_red, veh_yel, veh_grn, ped_red, ped_grn;

    int errors = 0;
    int checks = 0;
    int onehot_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    crossing_signal_ctrl u0 (
        .clk(clk), .rst(rst), .tick(tick), .fault(fault),
        .veh_red(veh_red), .veh_yel(veh_yel), .veh_grn(veh_grn),
        .ped_red(ped_red), .ped_grn(ped_grn)
    );

    // {req[3:0], tick, fault, lamps {vr,vy,vg,pr,pg}}
    localparam int NV = 19;
    localparam logic [10:0] VEC [NV] = '{
        {4'd3, 1'b1, 1'b0, 5'b10001},
        {4'd2, 1'b0, 1'b0, 5'b10001},
        {4'd3, 1'b1, 1'b0, 5'b10001},
        {4'd2, 1'b1, 1'b0, 5'b01010},
        {4'd3, 1'b1, 1'b0, 5'b00110},
        {4'd3, 1'b1, 1'b0, 5'b00110},
        {4'd2, 1'b1, 1'b0, 5'b01010},
        {4'd4, 1'b1, 1'b0, 5'b10001},
        {4'd6, 1'b0, 1'b1, 5'b00000},
        {4'd6, 1'b1, 1'b1, 5'b01000},
        {4'd6, 1'b0, 1'b1, 5'b01000},
        {4'd6, 1'b1, 1'b1, 5'b00000},
        {4'd6, 1'b1, 1'b1, 5'b01000},
        {4'd8, 1'b1, 1'b0, 5'b10001},
        {4'd8, 1'b1, 1'b0, 5'b10001},
        {4'd8, 1'b1, 1'b0, 5'b10001},
        {4'd8, 1'b1, 1'b0, 5'b01010},
        {4'd7, 1'b1, 1'b1, 5'b00000},
        {4'd9, 1'b0, 1'b0, 5'b10001}
    };

    function automatic string rname(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic step(input logic t, input logic f, input logic r);
        @(negedge clk);
        tick = t; fault = f; rst = r;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_lamps(input logic [4:0] exp, input string req);
        logic [4:0] act;
        act = {veh_red, veh_yel, veh_grn, ped_red, ped_grn};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s lamps=%b expected=%b", req, act, exp);
        end
        // R5: normal-mode lamps need one vehicle and one pedestrian lamp lit
        if (act[4:2] != 3'b000 && act != 5'b01000 &&
            ($countones(act[4:2]) != 1 || $countones(act[1:0]) != 1))
            onehot_bad++;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, reset held across a tick
        step(1'b1, 1'b0, 1'b1);
        expect_lamps(5'b10001, "R1");
        step(1'b0, 1'b0, 1'b0);
        expect_lamps(5'b10001, "R1");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6], VEC[i][5], 1'b0);
            expect_lamps(VEC[i][4:0], rname(int'(VEC[i][10:7])));
        end

        // R1: drive into green, then reset with fault high
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        expect_lamps(5'b00110, "R3");
        step(1'b1, 1'b1, 1'b1);
        expect_lamps(5'b10001, "R1");
        // R1: fresh dwell after reset: two ticks stay red, third leaves
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        expect_lamps(5'b10001, "R1");
        step(1'b1, 1'b0, 1'b0);
        expect_lamps(5'b01010, "R1");

        // R3: full 7-tick period from the first yellow back to it
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0);
        expect_lamps(5'b01010, "R3");

        checks++;
        if (onehot_bad != 0) begin
            errors++;
            $display("FAIL R5 onehot_violations=%0d expected=0", onehot_bad);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule